// File: doc/BRIEF.md
# Banked Register File Operand Sequencer

This block collects the source operands of one wide instruction bundle from a register file that is split into four banks. Each bank has one read port. A bundle has up to four slots, and each slot names three source registers. The sequencer works in repeating four-cycle groups. In phases 0, 1 and 2 every bank delivers at most one register, and the values read in phase k land in staging register k. Phase 3 is kept for writing results back into the file. Every register is one wavefront wide (`LANES` elements of `LANE_W` bits), so the whole wavefront is handled by one access.

Each slot carries a 3-bit ordering code that fixes the phase in which each of its three sources is fetched. The block never arbitrates between ALU reads. A bundle that would need two different registers from one bank in the same phase is rejected as a whole, with a one-cycle error pulse. The block has a single export client that can ask for one register. It is served in phase 2, and only when no ALU read claims the same bank in that phase. A denied client keeps its request up and is served in a later group.

Top module: `banked_operand_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high) forces `groupPhase` to 0, clears all staging registers, `expData` and every register-file entry to zero, and holds `bundleError`, `opsValid` and `expGrant` low.
- R2: `groupPhase` counts 0, 1, 2, 3 and wraps to 0. The bundle inputs (`bundleValid`, `slotEn`, `srcAddr`, `swzCode`) are sampled only on the clock edge that ends phase 3, and are ignored in every other phase.
- R3: A register's bank is its address modulo 4. During an accepted group, staging register k receives, in bank lane b, the register read from bank b in phase k; a bank read by nobody in phase k loads zero. `stageOps` bits `((k*4)+b)*REG_W` upward hold lane b of staging register k, and staging registers change only on the edges that end phases 0, 1 and 2 of an accepted group.
- R4: Source j of slot s sits at `srcAddr` bits `((s*3)+j)*AW` upward, and its code is `swzCode` bits `s*3` upward. Codes 0 to 5 place sources 0/1/2 into phases (0,1,2), (0,2,1), (1,0,2), (1,2,0), (2,0,1) and (2,1,0) respectively.
- R5: If two enabled reads need different registers from the same bank in the same phase, the bundle is dropped. `bundleError` is then high for exactly the phase-0 cycle that follows, the staging registers keep their contents, and `opsValid` stays low in that group.
- R6: Two enabled reads of the same register in the same phase are legal, and both receive that register's value.
- R7: An enabled slot with code 6 or 7 makes the bundle illegal, handled as in R5. Disabled slots never make a bundle illegal, whatever their codes or addresses.
- R8: `opsValid` is high in phase 3 of a group, and only then, when that group's bundle was accepted.
- R9: On the edge that ends phase 3, each slot with `wbValid` set writes `wbData` into register `wbAddr`. When two slots name the same register, the higher-numbered slot wins. The written value is visible to reads from the next phase 0.
- R10: When `expReq` is high in phase 2 and no ALU read uses bank `expAddr` mod 4 in that phase, `expGrant` is high for the following phase-3 cycle, and `expData` then holds register `expAddr`.
- R11: An export request that collides with an ALU read in phase 2 gets no grant. If the client holds the request, it is granted in the first later group whose phase 2 leaves that bank free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bundleValid | input | 1 | A bundle is offered (sampled when phase is 3) |
| slotEn | input | NUM_SLOTS | Per-slot enable |
| srcAddr | input | NUM_SLOTS*3*AW | Source register addresses, slot-major |
| swzCode | input | NUM_SLOTS*3 | Per-slot read-order code |
| wbValid | input | NUM_SLOTS | Per-slot write-back enable |
| wbAddr | input | NUM_SLOTS*AW | Write-back register addresses |
| wbData | input | NUM_SLOTS*REG_W | Write-back data |
| expReq | input | 1 | Export client requests a register |
| expAddr | input | AW | Register wanted by the export client |
| groupPhase | output | 2 | Current phase of the four-cycle group |
| bundleError | output | 1 | Offered bundle was rejected |
| opsValid | output | 1 | Staging registers hold the accepted bundle's operands |
| stageOps | output | 12*REG_W | Three staging registers, four bank lanes each |
| expGrant | output | 1 | Export read performed |
| expData | output | REG_W | Register returned to the export client |

## Verification
The assertions assume that the export client holds `expReq` for the whole of phase 2 and changes it only between clock edges. They also assume that reset lasts at least one clock edge before it is released. The stimulus meets both: the bench drives every input on the falling edge, and it changes the export request only at phase 3. Most bundles are built legal on purpose. Each read is placed into a free bank cell of its phase, or reuses a register already claimed there. The bench also offers unconstrained bundles and out-of-range codes, so the rejection path gets regular traffic.

// File: rtl/opsq_pkg.sv
package opsq_pkg;
  localparam int BANKS = 4;
  localparam int SRCS = 3;
  localparam int READ_PHASES = 3;

  typedef logic [1:0] phase_t;

  typedef struct packed {
    logic [READ_PHASES-1:0] stageLoad;
    logic [BANKS-1:0]       bankRd;
    logic                   wbEn;
    logic                   expLoad;
  } strobe_t;

  // Read phase of source src under order code; 3 marks an unusable code.
  function automatic logic [1:0] srcCycle(input logic [2:0] code, input logic [1:0] src);
    logic [5:0] map;
    case (code)
      3'd0:    map = {2'd2, 2'd1, 2'd0};
      3'd1:    map = {2'd1, 2'd2, 2'd0};
      3'd2:    map = {2'd2, 2'd0, 2'd1};
      3'd3:    map = {2'd0, 2'd2, 2'd1};
      3'd4:    map = {2'd1, 2'd0, 2'd2};
      3'd5:    map = {2'd0, 2'd1, 2'd2};
      default: map = 6'h3f;
    endcase
    return map[src*2 +: 2];
  endfunction
endpackage

// File: rtl/opsq_ctrl.sv
module opsq_ctrl
  import opsq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int AW = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bundleValid,
  input  logic [NUM_SLOTS-1:0]         slotEn,
  input  logic [NUM_SLOTS*SRCS*AW-1:0] srcAddr,
  input  logic [NUM_SLOTS*3-1:0]       swzCode,
  input  logic                         expReq,
  input  logic [AW-1:0]                expAddr,
  output phase_t                       phase,
  output logic                         bundleError,
  output logic                         opsValid,
  output logic                         expGrant,
  output strobe_t                      strobe,
  output logic [BANKS-1:0][AW-1:0]     bankAddr
);
  localparam int NUM_READS = NUM_SLOTS * SRCS;

  logic                   active;
  logic [NUM_SLOTS-1:0]   latEn;
  logic [NUM_READS*AW-1:0] latAddr;
  logic [NUM_SLOTS*3-1:0] latSwz;
  logic                   legal;
  logic [BANKS-1:0]       bankRd;

  // Static legality: bad codes or two different registers on one bank in one phase.
  always_comb begin
    legal = 1'b1;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slotEn[s] && (swzCode[s*3 +: 3] > 3'd5)) legal = 1'b0;
    end
    for (int a = 0; a < NUM_READS; a++) begin
      for (int b = a + 1; b < NUM_READS; b++) begin
        if (slotEn[a/SRCS] && slotEn[b/SRCS] &&
            (srcCycle(swzCode[(a/SRCS)*3 +: 3], 2'(a % SRCS)) ==
             srcCycle(swzCode[(b/SRCS)*3 +: 3], 2'(b % SRCS))) &&
            (srcAddr[a*AW +: 2] == srcAddr[b*AW +: 2]) &&
            (srcAddr[a*AW +: AW] != srcAddr[b*AW +: AW]))
          legal = 1'b0;
      end
    end
  end

  // Per-phase bank address selection from the latched bundle.
  always_comb begin
    bankRd   = '0;
    bankAddr = '0;
    if (active && (phase != 2'd3)) begin
      for (int a = 0; a < NUM_READS; a++) begin
        if (latEn[a/SRCS] &&
            (srcCycle(latSwz[(a/SRCS)*3 +: 3], 2'(a % SRCS)) == phase)) begin
          bankRd[latAddr[a*AW +: 2]]   = 1'b1;
          bankAddr[latAddr[a*AW +: 2]] = latAddr[a*AW +: AW];
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < READ_PHASES; k++) begin
      strobe.stageLoad[k] = active && (phase == 2'(k));
    end
    strobe.bankRd  = bankRd;
    strobe.wbEn    = (phase == 2'd3);
    strobe.expLoad = expReq && (phase == 2'd2) && !bankRd[expAddr[1:0]];
  end

  assign opsValid = active && (phase == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= 2'd0;
      active      <= 1'b0;
      latEn       <= '0;
      latAddr     <= '0;
      latSwz      <= '0;
      bundleError <= 1'b0;
      expGrant    <= 1'b0;
    end else begin
      phase       <= phase + 2'd1;
      expGrant    <= strobe.expLoad;
      bundleError <= 1'b0;
      if (phase == 2'd3) begin
        active      <= bundleValid && legal;
        bundleError <= bundleValid && !legal;
        if (bundleValid && legal) begin
          latEn   <= slotEn;
          latAddr <= srcAddr;
          latSwz  <= swzCode;
        end
      end
    end
  end
endmodule

// File: rtl/opsq_datapath.sv
module opsq_datapath
  import opsq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_REGS = 32,
  parameter int REG_W = 32,
  parameter int AW = 5
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  strobe_t                                 strobe,
  input  logic [BANKS-1:0][AW-1:0]                bankAddr,
  input  logic [NUM_SLOTS-1:0]                    wbValid,
  input  logic [NUM_SLOTS*AW-1:0]                 wbAddr,
  input  logic [NUM_SLOTS*REG_W-1:0]              wbData,
  input  logic [AW-1:0]                           expAddr,
  output logic [READ_PHASES*BANKS*REG_W-1:0]      stageOps,
  output logic [REG_W-1:0]                        expData
);
  logic [REG_W-1:0] rf [NUM_REGS];
  logic [BANKS-1:0][REG_W-1:0] rdVal;
  logic [READ_PHASES-1:0][BANKS-1:0][REG_W-1:0] stageQ;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign rdVal[b] = strobe.bankRd[b] ? rf[bankAddr[b]] : '0;
  end

  assign stageOps = stageQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) rf[r] <= '0;
      stageQ  <= '0;
      expData <= '0;
    end else begin
      if (strobe.wbEn) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          if (wbValid[s]) rf[wbAddr[s*AW +: AW]] <= wbData[s*REG_W +: REG_W];
        end
      end
      for (int k = 0; k < READ_PHASES; k++) begin
        if (strobe.stageLoad[k]) stageQ[k] <= rdVal;
      end
      if (strobe.expLoad) expData <= rf[expAddr];
    end
  end
endmodule

// File: rtl/banked_operand_sequencer.sv
module banked_operand_sequencer
  import opsq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int LANES = 4,
  parameter int LANE_W = 8,
  parameter int NUM_REGS = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                bundleValid,
  input  logic [NUM_SLOTS-1:0]                slotEn,
  input  logic [NUM_SLOTS*3*$clog2(NUM_REGS)-1:0] srcAddr,
  input  logic [NUM_SLOTS*3-1:0]              swzCode,
  input  logic [NUM_SLOTS-1:0]                wbValid,
  input  logic [NUM_SLOTS*$clog2(NUM_REGS)-1:0] wbAddr,
  input  logic [NUM_SLOTS*LANES*LANE_W-1:0]   wbData,
  input  logic                                expReq,
  input  logic [$clog2(NUM_REGS)-1:0]         expAddr,
  output logic [1:0]                          groupPhase,
  output logic                                bundleError,
  output logic                                opsValid,
  output logic [3*4*LANES*LANE_W-1:0]         stageOps,
  output logic                                expGrant,
  output logic [LANES*LANE_W-1:0]             expData
);
  localparam int REG_W = LANES * LANE_W;
  localparam int AW = $clog2(NUM_REGS);

  strobe_t strobe;
  logic [BANKS-1:0][AW-1:0] bankAddr;

  opsq_ctrl #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .bundleValid(bundleValid), .slotEn(slotEn),
    .srcAddr(srcAddr), .swzCode(swzCode), .expReq(expReq), .expAddr(expAddr),
    .phase(groupPhase), .bundleError(bundleError), .opsValid(opsValid),
    .expGrant(expGrant), .strobe(strobe), .bankAddr(bankAddr)
  );

  opsq_datapath #(.NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS), .REG_W(REG_W), .AW(AW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .bankAddr(bankAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData), .expAddr(expAddr),
    .stageOps(stageOps), .expData(expData)
  );
endmodule

// File: rtl/opsq_checker.sv
module opsq_checker #(
  parameter int OPS_W = 384
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       groupPhase,
  input logic             bundleError,
  input logic             opsValid,
  input logic             expReq,
  input logic             expGrant,
  input logic [OPS_W-1:0] stageOps
);
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (groupPhase == 2'd3) |=> (groupPhase == 2'd0)); // R2

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (groupPhase == 2'd0) |-> $stable(stageOps)); // R3

  AST_ERR_PHASE: assert property (@(posedge clk) disable iff (rst)
    bundleError |-> (groupPhase == 2'd0)); // R5

  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (rst)
    bundleError |-> ##3 !opsValid); // R5

  AST_OPS_PHASE: assert property (@(posedge clk) disable iff (rst)
    opsValid |-> (groupPhase == 2'd3)); // R8

  AST_GRANT_PHASE: assert property (@(posedge clk) disable iff (rst)
    expGrant |-> ((groupPhase == 2'd3) && $past(expReq))); // R10

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
    expGrant |=> !expGrant); // R10
endmodule

bind banked_operand_sequencer opsq_checker #(.OPS_W(3*4*REG_W)) u_opsq_checker (
  .clk(clk), .rst(rst), .groupPhase(groupPhase), .bundleError(bundleError),
  .opsValid(opsValid), .expReq(expReq), .expGrant(expGrant), .stageOps(stageOps)
);

// File: tb/test_banked_operand_sequencer.sv
module test_banked_operand_sequencer;
  localparam int NUM_SLOTS = 4;
  localparam int LANES = 4;
  localparam int LANE_W = 8;
  localparam int NUM_REGS = 32;
  localparam int REG_W = LANES * LANE_W;
  localparam int AW = $clog2(NUM_REGS);
  localparam int OPS_W = 3 * 4 * REG_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bundleValid = 1'b0;
  logic [NUM_SLOTS-1:0] slotEn = '0;
  logic [NUM_SLOTS*3*AW-1:0] srcAddr = '0;
  logic [NUM_SLOTS*3-1:0] swzCode = '0;
  logic [NUM_SLOTS-1:0] wbValid = '0;
  logic [NUM_SLOTS*AW-1:0] wbAddr = '0;
  logic [NUM_SLOTS*REG_W-1:0] wbData = '0;
  logic expReq = 1'b0;
  logic [AW-1:0] expAddr = '0;
  logic [1:0] groupPhase;
  logic bundleError, opsValid, expGrant;
  logic [OPS_W-1:0] stageOps;
  logic [REG_W-1:0] expData;

  always #4 clk = ~clk;

  banked_operand_sequencer #(.NUM_SLOTS(NUM_SLOTS), .LANES(LANES), .LANE_W(LANE_W),
                             .NUM_REGS(NUM_REGS)) i_banked_operand_sequencer (
    .clk(clk), .rst(rst), .bundleValid(bundleValid), .slotEn(slotEn), .srcAddr(srcAddr),
    .swzCode(swzCode), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .expReq(expReq), .expAddr(expAddr), .groupPhase(groupPhase), .bundleError(bundleError),
    .opsValid(opsValid), .stageOps(stageOps), .expGrant(expGrant), .expData(expData)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [REG_W-1:0] mrf [NUM_REGS];
  int bEn [NUM_SLOTS];
  int bAddr [NUM_SLOTS][3];
  int bSwz [NUM_SLOTS];
  logic [OPS_W-1:0] expStage = '0;
  bit expAcc = 0;
  bit grantExp = 0;
  logic [REG_W-1:0] grantData = '0;

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Phase of source src under order code, built as a permutation enumeration.
  function automatic int cycOf(int code, int src);
    int first, lo, hi;
    first = code / 2;
    lo = (first == 0) ? 1 : 0;
    hi = (first == 2) ? 1 : 2;
    if (src == 0) return first;
    if ((code % 2) == 0) return (src == 1) ? lo : hi;
    return (src == 1) ? hi : lo;
  endfunction

  function automatic bit bundleLegal();
    for (int s = 0; s < NUM_SLOTS; s++)
      if (bEn[s] != 0 && bSwz[s] > 5) return 0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int j = 0; j < 3; j++)
        for (int t = 0; t < NUM_SLOTS; t++)
          for (int i = 0; i < 3; i++)
            if (bEn[s] != 0 && bEn[t] != 0 && (s != t || i != j) &&
                cycOf(bSwz[s], j) == cycOf(bSwz[t], i) &&
                bAddr[s][j] % 4 == bAddr[t][i] % 4 && bAddr[s][j] != bAddr[t][i])
              return 0;
    return 1;
  endfunction

  function automatic bit bankInPhase2(int bank);
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int j = 0; j < 3; j++)
        if (bEn[s] != 0 && cycOf(bSwz[s], j) == 2 && bAddr[s][j] % 4 == bank) return 1;
    return 0;
  endfunction

  task automatic clearBundle();
    for (int s = 0; s < NUM_SLOTS; s++) begin
      bEn[s] = 0; bSwz[s] = 0;
      for (int j = 0; j < 3; j++) bAddr[s][j] = 0;
    end
  endtask

  task automatic genLegal();
    int occ [3][4];
    for (int c = 0; c < 3; c++) for (int b = 0; b < 4; b++) occ[c][b] = -1;
    clearBundle();
    for (int s = 0; s < NUM_SLOTS; s++) begin
      bEn[s] = ($urandom % 4 != 0) ? 1 : 0;
      bSwz[s] = $urandom % 6;
      if (bEn[s] != 0) begin
        for (int j = 0; j < 3; j++) begin
          int c, r, pick;
          c = cycOf(bSwz[s], j);
          r = $urandom % 4;
          pick = -1;
          if ($urandom % 5 == 0 && occ[c][r] >= 0) pick = occ[c][r];
          for (int t = 0; t < 4 && pick < 0; t++) begin
            int b;
            b = (r + t) % 4;
            if (occ[c][b] < 0) begin
              pick = b + 4 * int'($urandom % (NUM_REGS / 4));
              occ[c][b] = pick;
            end
          end
          bAddr[s][j] = pick;
        end
      end
    end
  endtask

  task automatic genRaw();
    for (int s = 0; s < NUM_SLOTS; s++) begin
      bEn[s] = $urandom % 2;
      bSwz[s] = ($urandom % 8 == 0) ? 6 + int'($urandom % 2) : int'($urandom % 6);
      for (int j = 0; j < 3; j++) bAddr[s][j] = $urandom % NUM_REGS;
    end
  endtask

  task automatic drivePorts();
    for (int s = 0; s < NUM_SLOTS; s++) begin
      slotEn[s] = (bEn[s] != 0);
      swzCode[s*3 +: 3] = 3'(bSwz[s]);
      for (int j = 0; j < 3; j++) srcAddr[((s*3)+j)*AW +: AW] = AW'(bAddr[s][j]);
    end
  endtask

  task automatic setWb(int s, int addr, logic [REG_W-1:0] data);
    wbValid[s] = 1'b1;
    wbAddr[s*AW +: AW] = AW'(addr);
    wbData[s*REG_W +: REG_W] = data;
  endtask

  task automatic stepPhase(input logic [1:0] want);
    @(negedge clk);
    chk(groupPhase == want, "R2 phase", 512'(groupPhase), 512'(want));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'h0005eed5);
    for (int r = 0; r < NUM_REGS; r++) mrf[r] = '0;
    clearBundle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(groupPhase == 2'd0, "R1 phase", 512'(groupPhase), 0);
    chk(!opsValid && !bundleError && !expGrant, "R1 flags",
        512'({opsValid, bundleError, expGrant}), 0);
    chk(stageOps == '0 && expData == '0, "R1 staging", 512'(stageOps), 0);
    rst = 1'b0;
    stepPhase(2'd1); stepPhase(2'd2); stepPhase(2'd3);

    for (int it = 0; it < 400; it++) begin
      bit legal, acc;
      // Results of the group that just finished
      chk(opsValid == expAcc, "R8 opsValid", 512'(opsValid), 512'(expAcc));
      chk(stageOps == expStage, "R3 R4 staged operands", 512'(stageOps), 512'(expStage));
      chk(expGrant == grantExp, "R10 R11 export grant", 512'(expGrant), 512'(grantExp));
      if (grantExp) begin
        chk(expData == grantData, "R10 export data", 512'(expData), 512'(grantData));
        expReq = 1'b0;
      end
      if (it >= 9 && !expReq && $urandom % 2 == 0) begin
        expReq = 1'b1;
        expAddr = AW'($urandom % NUM_REGS);
      end

      // Write-back for this phase-3 edge
      wbValid = '0;
      if (it == 1) begin
        for (int s = 0; s < NUM_SLOTS; s++)
          for (int j = 0; j < 3; j++)
            if (s + 4*j < 16) begin end
        for (int s = 0; s < NUM_SLOTS; s++) setWb(s, s + 4 * (s % 3), REG_W'($urandom));
      end else if (it == 5) begin
        setWb(1, 9, 32'h1111_aaaa);   // R9: lower slot loses
        setWb(3, 9, 32'h3333_bbbb);
      end else if (it != 0 && it != 2 && it != 3 && it != 4) begin
        for (int s = 0; s < NUM_SLOTS; s++)
          if ($urandom % 2 == 0) setWb(s, $urandom % NUM_REGS, REG_W'($urandom));
      end
      for (int s = 0; s < NUM_SLOTS; s++)
        if (wbValid[s]) mrf[wbAddr[s*AW +: AW]] = wbData[s*REG_W +: REG_W];

      // Bundle for the next group
      clearBundle();
      bundleValid = 1'b1;
      case (it)
        0: bundleValid = 1'b0;
        1: for (int s = 0; s < NUM_SLOTS; s++) begin
             bEn[s] = 1;
             for (int j = 0; j < 3; j++) bAddr[s][j] = s + 4 * j;
           end
        2: begin // R5: bank 1 in phase 0 asked for registers 1 and 5
             bEn[0] = 1; bAddr[0][0] = 1; bAddr[0][1] = 2; bAddr[0][2] = 3;
             bEn[1] = 1; bAddr[1][0] = 5; bAddr[1][1] = 8; bAddr[1][2] = 12;
           end
        3: begin // R6 same register twice; R7 disabled slot with code 7 and clashes
             bEn[0] = 1; bAddr[0][0] = 6; bAddr[0][1] = 1; bAddr[0][2] = 3;
             bEn[1] = 1; bAddr[1][0] = 6; bAddr[1][1] = 0; bAddr[1][2] = 12;
             bEn[3] = 0; bSwz[3] = 7; bAddr[3][0] = 2; bAddr[3][1] = 5; bAddr[3][2] = 7;
           end
        4: begin // R7: code 6 on an enabled slot
             bEn[0] = 1; bSwz[0] = 6; bAddr[0][0] = 0; bAddr[0][1] = 1; bAddr[0][2] = 2;
           end
        5: bundleValid = 1'b0;
        6: begin // R9: read back register 9 (code 5 puts source 0 in phase 2)
             bEn[0] = 1; bSwz[0] = 5; bAddr[0][0] = 9; bAddr[0][1] = 10; bAddr[0][2] = 11;
           end
        7: begin // R11: bank 2 taken in phase 2 while export wants register 2
             bEn[0] = 1; bAddr[0][0] = 0; bAddr[0][1] = 1; bAddr[0][2] = 6;
             expReq = 1'b1; expAddr = AW'(2);
           end
        8: bundleValid = 1'b0;
        default: begin
          if ($urandom % 10 < 7) genLegal(); else genRaw();
          if ($urandom % 12 == 0) bundleValid = 1'b0;
        end
      endcase
      legal = bundleLegal();
      acc = bundleValid && legal;
      if (acc) begin
        expStage = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
          for (int j = 0; j < 3; j++)
            if (bEn[s] != 0)
              expStage[((cycOf(bSwz[s], j) * 4) + (bAddr[s][j] % 4)) * REG_W +: REG_W] =
                mrf[bAddr[s][j]];
      end
      expAcc = acc;
      grantExp = expReq && !(acc && bankInPhase2(int'(expAddr) % 4));
      grantData = mrf[expAddr];
      drivePorts();

      stepPhase(2'd0);
      chk(bundleError == (bundleValid && !legal), "R5 R7 bundle error",
          512'(bundleError), 512'(bundleValid && !legal));
      bundleValid = 1'b0;
      wbValid = '0;
      // R2: bundle inputs outside phase 3 must have no effect
      slotEn = '1; swzCode = '1; srcAddr = '1;
      stepPhase(2'd1);
      chk(!bundleError, "R5 error pulse width", 512'(bundleError), 0);
      stepPhase(2'd2);
      stepPhase(2'd3);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule